// File: doc/BRIEF.md
# Programmable CAS-Latency Read Pipeline

This block produces the read-data timing of a synchronous DRAM data port. A read command strobe, together with the word fetched from the array, enters on one clock edge. The word appears on the output a programmed number of clocks later, either two or three. The output-drive enable comes on one clock before the word is valid and stays on for one clock after the last word. Reads issued on consecutive clocks come out on consecutive clocks, with no gap between them and in the order they were issued.

Two configuration fields set the latency. One is a three-bit latency code. The other is a two-bit operating-mode field. Any code that is not defined raises an error flag, and new reads are refused for as long as the flag is up. The data flows one way only and has no ready signal. The output cannot be stalled, so the consumer must take each beat in the single cycle that `dq_valid` is high. On the input side, the strobe is the valid and the block is always ready, except while `cfg_err` is high.

Top module: `cas_read_pipe`

## Requirements
- R1: During reset and in the first cycle after it, `dq_valid`, `dq_oe` and `cfg_err` are low and `dq_out` is zero.
- R2: `cfg_lat` code 3'b010 selects latency 2 and code 3'b011 selects latency 3. An accepted read registered at edge n with latency m makes `dq_valid` high for exactly the one cycle that follows edge n+m.
- R3: `dq_oe` rises as a result of edge n+m-1, so it is high during the cycle before that read's valid cycle.
- R4: `dq_oe` stays high through every valid beat and for one more cycle after the last valid beat, then it falls.
- R5: Reads accepted on consecutive edges give valid beats on consecutive cycles. The words keep the order in which they were issued, and each output word equals the `rd_word` sampled with its command.
- R6: `dq_out` is zero in every cycle where `dq_valid` is low.
- R7: `cfg_err` is high, combinationally, whenever `cfg_lat` is anything other than 3'b010 or 3'b011, or `cfg_op` is anything other than 2'b00.
- R8: A read strobe presented while `cfg_err` is high is dropped and produces no beat. Beats already in flight still complete.
- R9: A new latency is adopted only on an edge where no accepted read is still waiting in the pipeline. A read issued while earlier reads are pending uses the latency held for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Read command strobe, registered on the rising edge |
| rd_word | input | DW | Array word captured with the read command |
| cfg_lat | input | 3 | Latency code (3'b010 = 2, 3'b011 = 3, others reserved) |
| cfg_op | input | 2 | Operating-mode field (2'b00 = normal, others reserved) |
| dq_out | output | DW | Read data, zero when not valid |
| dq_oe | output | 1 | Output-drive enable |
| dq_valid | output | 1 | Read data valid |
| cfg_err | output | 1 | Reserved configuration present; reads refused |

## Verification
The bench switches `cfg_lat` to a different code while a stream at the other latency is still in flight. A design that adopts the change at once would either collide two beats in one slot or open a gap in the stream. Reads are also issued into reserved latency codes and reserved mode values, including while a legal read is still draining. A design that honours a reserved code emits a beat that nobody expects, and one that flushes the pipeline on error loses the pending beat. The drive enable is compared cycle by cycle against the expected valid pattern. This catches an enable that rises together with the data instead of a cycle ahead, or one that drops at the same edge as the last beat instead of one cycle later.

// File: rtl/cas_rd_pkg.sv
package cas_rd_pkg;
  localparam logic [2:0] CODE_CL2  = 3'b010;
  localparam logic [2:0] CODE_CL3  = 3'b011;
  localparam logic [1:0] OP_NORMAL = 2'b00;
endpackage

// File: rtl/cas_mode_decode.sv
module cas_mode_decode #(
  parameter int LW = 2
) (
  input  logic [2:0]    cfg_lat,
  input  logic [1:0]    cfg_op,
  output logic          lat_ok,
  output logic [LW-1:0] lat_val,
  output logic          mode_err
);
  import cas_rd_pkg::*;

  always_comb begin
    lat_ok  = 1'b0;
    lat_val = '0;
    case (cfg_lat)
      CODE_CL2: begin lat_ok = 1'b1; lat_val = LW'(2); end
      CODE_CL3: begin lat_ok = 1'b1; lat_val = LW'(3); end
      default:  begin lat_ok = 1'b0; lat_val = '0;     end
    endcase
    mode_err = !lat_ok || (cfg_op != OP_NORMAL);
  end
endmodule

// File: rtl/cas_lat_hold.sv
module cas_lat_hold #(
  parameter int LW      = 2,
  parameter int MAX_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          lat_ok,
  input  logic [LW-1:0] lat_val,
  output logic [LW-1:0] lat_use
);
  logic [LW-1:0] lat_q;

  // a fresh latency only applies when the stages hold nothing
  always_comb lat_use = (!busy && lat_ok) ? lat_val : lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    lat_q <= LW'(MAX_LAT);
    else if (!busy) lat_q <= lat_use;
  end
endmodule

// File: rtl/cas_beat_pipe.sv
module cas_beat_pipe #(
  parameter int DW    = 16,
  parameter int DEPTH = 3,
  parameter int LW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [LW-1:0] push_lat,
  output logic          out_v,
  output logic [DW-1:0] out_d,
  output logic          oe,
  output logic          busy
);
  logic          st_v   [DEPTH];
  logic [DW-1:0] st_d   [DEPTH];
  logic          st_v_n [DEPTH];
  logic [DW-1:0] st_d_n [DEPTH];

  // slot k drains to the output after k+1 more edges, so a read with
  // latency m enters slot m-1
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (int'(push_lat) == i + 1)) begin
        st_v_n[i] = 1'b1;
        st_d_n[i] = push_data;
      end else if (i < DEPTH - 1) begin
        st_v_n[i] = st_v[i+1];
        st_d_n[i] = st_d[i+1];
      end else begin
        st_v_n[i] = 1'b0;
        st_d_n[i] = '0;
      end
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) busy = busy | st_v[i];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_v[g] <= 1'b0;
        st_d[g] <= '0;
      end else begin
        st_v[g] <= st_v_n[g];
        st_d[g] <= st_d_n[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_d <= '0;
      oe    <= 1'b0;
    end else begin
      out_v <= st_v[0];
      out_d <= st_v[0] ? st_d[0] : '0;
      // on a cycle ahead of the beat, through it, and one cycle after it
      oe    <= st_v_n[0] | st_v[0] | out_v;
    end
  end
endmodule

// File: rtl/cas_read_pipe.sv
module cas_read_pipe #(
  parameter int DW      = 16,
  parameter int MAX_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cmd,
  input  logic [DW-1:0] rd_word,
  input  logic [2:0]    cfg_lat,
  input  logic [1:0]    cfg_op,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          dq_valid,
  output logic          cfg_err
);
  localparam int LW = $clog2(MAX_LAT + 1);

  logic          lat_ok;
  logic [LW-1:0] lat_val;
  logic [LW-1:0] lat_use;
  logic          pipe_busy;
  logic          accept;

  cas_mode_decode #(.LW(LW)) u_dec (
    .cfg_lat  (cfg_lat),
    .cfg_op   (cfg_op),
    .lat_ok   (lat_ok),
    .lat_val  (lat_val),
    .mode_err (cfg_err)
  );

  cas_lat_hold #(.LW(LW), .MAX_LAT(MAX_LAT)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (pipe_busy),
    .lat_ok  (lat_ok),
    .lat_val (lat_val),
    .lat_use (lat_use)
  );

  assign accept = rd_cmd && !cfg_err;

  cas_beat_pipe #(.DW(DW), .DEPTH(MAX_LAT), .LW(LW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (rd_word),
    .push_lat  (lat_use),
    .out_v     (dq_valid),
    .out_d     (dq_out),
    .oe        (dq_oe),
    .busy      (pipe_busy)
  );
endmodule

// File: rtl/cas_read_pipe_chk.sv
module cas_read_pipe_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_cmd,
  input logic [2:0]    cfg_lat,
  input logic [1:0]    cfg_op,
  input logic          cfg_err,
  input logic          dq_valid,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          pipe_busy
);
  // R2
  cl2_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !cfg_err && !pipe_busy && cfg_lat == 3'b010) |-> ##3 dq_valid);
  // R2
  cl3_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !cfg_err && !pipe_busy && cfg_lat == 3'b011) |-> ##4 dq_valid);
  // R3
  oe_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe));
  // R4
  oe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dq_oe);
  // R4
  oe_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_valid) |-> dq_oe);
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> (dq_out == '0));
  // R7
  op_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_op != 2'b00) |-> cfg_err);
  // R8
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !pipe_busy) |=> !pipe_busy);
endmodule

bind cas_read_pipe cas_read_pipe_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_cmd    (rd_cmd),
  .cfg_lat   (cfg_lat),
  .cfg_op    (cfg_op),
  .cfg_err   (cfg_err),
  .dq_valid  (dq_valid),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .pipe_busy (pipe_busy)
);

// File: tb/cas_read_pipe_test.sv
module cas_read_pipe_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_cmd = 1'b0;
  logic [DW-1:0] rd_word = '0;
  logic [2:0]    cfg_lat = 3'b010;
  logic [1:0]    cfg_op = 2'b00;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          dq_valid;
  logic          cfg_err;

  cas_read_pipe #(.DW(DW), .MAX_LAT(3)) uut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_word(rd_word),
    .cfg_lat(cfg_lat), .cfg_op(cfg_op), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_valid(dq_valid), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  bit exp_v [0:4095];
  logic [DW-1:0] sb_q [$];
  int max_due = -1;
  int cur_lat = 3;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic bit cfg_bad();
    return !((cfg_lat == 3'b010 || cfg_lat == 3'b011) && cfg_op == 2'b00);
  endfunction

  // driver: called at a falling edge, schedules expected beat, strobes one cycle
  task automatic issue(input logic [DW-1:0] w);
    if (!cfg_bad()) begin
      if (max_due < cyc + 1) cur_lat = (cfg_lat == 3'b010) ? 2 : 3;
      exp_v[cyc + 1 + cur_lat] = 1'b1;
      max_due = cyc + 1 + cur_lat;
      sb_q.push_back(w);
    end
    rd_cmd = 1'b1;
    rd_word = w;
    @(negedge clk);
    rd_cmd = 1'b0;
    rd_word = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: compares outputs against the scoreboard each falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      automatic int t = cyc;
      automatic bit oe_exp = exp_v[t+1] | exp_v[t] | ((t > 0) ? exp_v[t-1] : 1'b0);
      check(dq_valid == exp_v[t], "R2 R5 R8", {phase, " dq_valid"}, dq_valid, exp_v[t]);
      check(dq_oe == oe_exp, "R3 R4", {phase, " dq_oe"}, dq_oe, oe_exp);
      if (dq_valid) begin
        if (sb_q.size() == 0) check(1'b0, "R8", "unexpected beat", dq_out, 0);
        else begin
          automatic logic [DW-1:0] e = sb_q.pop_front();
          check(dq_out == e, "R5", {phase, " word order"}, dq_out, e);
        end
      end else begin
        check(dq_out == '0, "R6", "idle data", dq_out, 0);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    idle(3);
    // R1 reset state
    check(!dq_valid && !dq_oe && !cfg_err && dq_out == '0, "R1", "reset outputs",
          {dq_valid, dq_oe, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dq_valid && !dq_oe && dq_out == '0, "R1", "after reset", {dq_valid, dq_oe}, 0);
    mon_on = 1'b1;
    idle(1);

    phase = "R2 single CL2";
    issue(16'hA001); idle(6);

    phase = "R2 single CL3";
    cfg_lat = 3'b011; idle(1);
    issue(16'hB001); idle(7);

    phase = "R5 burst CL3";
    for (int k = 0; k < 4; k++) issue(16'hC000 + 16'(k));
    idle(8);

    phase = "R5 burst CL2";
    cfg_lat = 3'b010; idle(2);
    for (int k = 0; k < 5; k++) issue(16'hD000 + 16'(k));
    idle(6);

    phase = "R9 change in flight";
    cfg_lat = 3'b011;
    issue(16'hE000);
    cfg_lat = 3'b010;
    issue(16'hE001);
    issue(16'hE002);
    idle(8);
    issue(16'hE003);
    idle(6);

    phase = "R7 R8 reserved codes";
    cfg_lat = 3'b001; #1;
    check(cfg_err == 1'b1, "R7", "lat code 001", cfg_err, 1);
    issue(16'hF001); idle(6);
    cfg_lat = 3'b111; #1;
    check(cfg_err == 1'b1, "R7", "lat code 111", cfg_err, 1);
    cfg_lat = 3'b011; cfg_op = 2'b01; #1;
    check(cfg_err == 1'b1, "R7", "op 01", cfg_err, 1);
    issue(16'hF002); idle(6);
    cfg_op = 2'b10; #1;
    check(cfg_err == 1'b1, "R7", "op 10", cfg_err, 1);
    cfg_op = 2'b11; #1;
    check(cfg_err == 1'b1, "R7", "op 11", cfg_err, 1);
    cfg_lat = 3'b010; cfg_op = 2'b00; #1;
    check(cfg_err == 1'b0, "R7", "legal again", cfg_err, 0);
    @(negedge clk);
    issue(16'hF003); idle(6);

    phase = "R8 error while draining";
    issue(16'hF100);
    cfg_op = 2'b01;
    issue(16'hF101);
    cfg_op = 2'b00;
    idle(8);

    check(sb_q.size() == 0, "R5", "scoreboard drained", sb_q.size(), 0);
    report();
  end
endmodule